// File: doc/BRIEF.md
# SPI Memory Write-Enable Gate

This block is the command front end of an SPI serial memory slave. While chip select is low it shifts in the instruction stream on the serial input. When chip select rises it decides whether the frame that just ended may change anything. A write-enable latch controls every array write and every status-register write. Two block-protect bits split the array into regions that cannot be written. An accepted array write is passed on as a one-cycle grant pulse, together with the 11-bit address and the data byte. The nonvolatile array itself sits behind that grant.

The serial pins are oversampled by the block's own clock through two-stage synchronizers. Serial data is taken on rising SCK edges, so both clock-idle-low mode (0,0) and clock-idle-high mode (1,1) work without any mode setting. The frame counts are checked only at the end of the frame. A frame takes effect only if it has exactly the length its instruction needs and ends on a byte boundary.

Top module: `spi_wen_gate`

## Requirements
- R1: After reset, status reads 0x00 (write-enable latch clear, protect bits 00) and no grant is issued.
- R2: An array write (opcode 0x02) or status write (opcode 0x01) with the write-enable latch clear produces no grant and changes no status bit.
- R3: Opcode 0x06 sets the write-enable latch only when chip select rises right after that single byte. If the frame carries more bytes, the latch keeps its previous value.
- R4: Opcode 0x04, sent as a single-byte frame, clears the write-enable latch.
- R5: The protect field P = status[3:2] refuses writes by address: with P=00 none are refused, with 01 addresses 0x600 to 0x7FF, with 10 addresses 0x400 to 0x7FF, and with 11 all addresses. A refused write gives no grant and leaves the latch set.
- R6: An accepted array write is a frame of exactly four bytes, each sent MSB first: opcode 0x02, address high, address low, data. The address is the low 11 bits of the 16 address bits. The frame raises wr_grant for exactly one clock after chip select rises, with wr_addr and wr_data carrying that address and data.
- R7: An accepted status write is a frame of exactly two bytes: opcode 0x01, then a data byte. It loads data bits 3:2 into the protect field status[3:2].
- R8: An accepted array write or status write clears the write-enable latch. Status bit 1 always shows the latch, and bits 7:4 and 0 read zero.
- R9: A frame that ends with a partial byte (a bit count that is not a multiple of eight) changes no state and gives no grant.
- R10: Frames are decoded identically in SPI mode (0,0) and mode (1,1).
- R11: Any opcode other than 0x06, 0x04, 0x02 and 0x01 leaves all state unchanged.
- R12: The write-enable latch and the protect bits change only while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock; data is taken on its rising edges |
| si | input | 1 | Serial data in, MSB first |
| wr_grant | output | 1 | One-clock pulse for an accepted array write |
| wr_addr | output | 11 | Address of the granted write |
| wr_data | output | 8 | Data of the granted write |
| status | output | 8 | Status bits: [3:2] protect field, [1] write-enable latch |

## Verification
The assertions assume three things about the inputs. Chip select stays high for several block clocks after each frame, so a status change is seen while cs_n is still high. Each SCK phase lasts longer than the synchronizer delay. Reset is held through the first clock edges. The stimulus keeps within these limits by driving each SCK half period as four block clocks and holding chip select high for a dozen clocks between frames. Inside those limits it draws opcodes, frame lengths, addresses, data bytes, SPI modes and truncated frames at random.

// File: rtl/spi_wen_gate.sv
module spi_wen_gate #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              wr_grant,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [7:0]        status
);
  localparam int FRAME_W = 4 * DATA_W;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_WR   = 8'h02;
  localparam logic [7:0] OP_WRSR = 8'h01;

  logic [2:0] cs_s, sck_s, si_s;
  logic [2:0] bit_cnt, byte_cnt;
  logic [FRAME_W-1:0] frame;
  logic wel;
  logic [1:0] bp;

  wire sel     = ~cs_s[1];
  wire sck_up  = sel & sck_s[1] & ~sck_s[2];
  wire cs_up   = cs_s[1] & ~cs_s[2];
  wire aligned = (bit_cnt == 3'd0);

  wire [7:0]        op1  = frame[7:0];
  wire [7:0]        op2  = frame[15:8];
  wire [7:0]        op4  = frame[31:24];
  wire [ADDR_W-1:0] addr = frame[8 +: ADDR_W];

  logic in_prot;
  always_comb begin
    case (bp)
      2'b00:   in_prot = 1'b0;
      2'b01:   in_prot = addr[ADDR_W-1] & addr[ADDR_W-2];
      2'b10:   in_prot = addr[ADDR_W-1];
      default: in_prot = 1'b1;
    endcase
  end

  wire do_wen  = cs_up && aligned && byte_cnt == 3'd1 && op1 == OP_WEN;
  wire do_wdis = cs_up && aligned && byte_cnt == 3'd1 && op1 == OP_WDIS;
  wire do_wrsr = cs_up && aligned && byte_cnt == 3'd2 && op2 == OP_WRSR && wel;
  wire do_wr   = cs_up && aligned && byte_cnt == 3'd4 && op4 == OP_WR && wel && !in_prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s  <= 3'b111;
      sck_s <= 3'b000;
      si_s  <= 3'b000;
    end else begin
      cs_s  <= {cs_s[1:0], cs_n};
      sck_s <= {sck_s[1:0], sck};
      si_s  <= {si_s[1:0], si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      frame    <= '0;
    end else if (!sel) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else if (sck_up) begin
      frame   <= {frame[FRAME_W-2:0], si_s[1]};
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7 && byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      bp       <= 2'b00;
      wr_grant <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_grant <= do_wr;
      if (do_wen)  wel <= 1'b1;
      if (do_wdis) wel <= 1'b0;
      if (do_wrsr) begin
        bp  <= frame[3:2];
        wel <= 1'b0;
      end
      if (do_wr) begin
        wel     <= 1'b0;
        wr_addr <= addr;
        wr_data <= frame[DATA_W-1:0];
      end
    end
  end

  assign status = {4'b0000, bp, wel, 1'b0};
endmodule

// File: rtl/spi_wen_gate_chk.sv
module spi_wen_gate_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wr_grant,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        status
);
  function automatic logic blocked(input logic [ADDR_W-1:0] a, input logic [1:0] p);
    case (p)
      2'b00:   return 1'b0;
      2'b01:   return a >= ADDR_W'(3 * (2 ** ADDR_W) / 4);
      2'b10:   return a >= ADDR_W'((2 ** ADDR_W) / 2);
      default: return 1'b1;
    endcase
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (status == 8'h00) && !wr_grant); // R1
  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) wr_grant |-> $past(status[1])); // R2
  AST_GRANT_OUTSIDE_PROT: assert property (@(posedge clk) disable iff (!rst_n) wr_grant |-> !blocked(wr_addr, status[3:2])); // R5
  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wr_grant |=> !wr_grant); // R6
  AST_WEL_CLEARED_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n) wr_grant |-> !status[1]); // R8
  AST_FIXED_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n) status[7:4] == 4'h0 && !status[0]); // R8
  AST_STATE_CHANGES_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) !$stable(status) |-> cs_n); // R12
endmodule

bind spi_wen_gate spi_wen_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_spi_wen_gate.sv
module test_spi_wen_gate;
  localparam int H = 4;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic wr_grant;
  logic [10:0] wr_addr;
  logic [7:0] wr_data, status;
  int n_chk = 0, n_fail = 0, n_grant = 0;
  logic [10:0] g_addr;
  logic [7:0] g_data;
  logic m_wel = 1'b0;
  logic [1:0] m_bp = 2'b00;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_wen_gate i_spi_wen_gate (.*);

  always @(negedge clk) if (wr_grant) begin
    n_grant++;
    g_addr = wr_addr;
    g_data = wr_data;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit prot(input logic [10:0] a, input logic [1:0] p);
    return (p == 2'b11) || (p == 2'b10 && a >= 11'h400) || (p == 2'b01 && a >= 11'h600);
  endfunction

  task automatic send(input logic [31:0] pl, input int nb, input int extra, input bit m3);
    sck = m3;
    repeat (H) @(posedge clk);
    cs_n = 1'b0;
    repeat (H) @(posedge clk);
    for (int i = 8 * nb - 1 + extra; i >= 0; i--) begin
      if (m3) sck = 1'b0;
      si = (i >= extra) ? pl[i - extra] : 1'($urandom);
      repeat (H) @(posedge clk);
      sck = 1'b1;
      repeat (H) @(posedge clk);
      if (!m3) sck = 1'b0;
    end
    repeat (H) @(posedge clk);
    cs_n = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] op, input int nb, input logic [15:0] a, input logic [7:0] d,
                       input int extra, input bit m3, input string req);
    logic [31:0] pl;
    bit eg = 1'b0;
    int g0 = n_grant;
    pl = (nb == 4) ? {op, a, d} : (nb == 3) ? {8'h0, op, a} : (nb == 2) ? {16'h0, op, d} : {24'h0, op};
    send(pl, nb, extra, m3);
    if (extra == 0) begin
      if (nb == 1 && op == 8'h06) m_wel = 1'b1;
      else if (nb == 1 && op == 8'h04) m_wel = 1'b0;
      else if (nb == 2 && op == 8'h01 && m_wel) begin m_bp = d[3:2]; m_wel = 1'b0; end
      else if (nb == 4 && op == 8'h02 && m_wel && !prot(a[10:0], m_bp)) begin eg = 1'b1; m_wel = 1'b0; end
    end
    check(status == {4'h0, m_bp, m_wel, 1'b0}, req, status, {4'h0, m_bp, m_wel, 1'b0});
    check((n_grant - g0) == int'(eg), req, n_grant - g0, eg);
    if (eg) check({g_addr, g_data} == {a[10:0], d}, req, {g_addr, g_data}, {a[10:0], d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(status == 8'h00 && !wr_grant, "R1 reset", {wr_grant, status}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(status == 8'h00 && n_grant == 0, "R1 after reset", status, 0);
    frame(8'h02, 4, 16'h0123, 8'hA5, 0, 0, "R2 write without latch");
    frame(8'h01, 2, 0, 8'h0C, 0, 0, "R2 status write without latch");
    frame(8'h06, 2, 0, 8'h00, 0, 0, "R3 enable with extra byte");
    frame(8'h06, 1, 0, 0, 0, 0, "R3 enable");
    frame(8'h04, 1, 0, 0, 0, 0, "R4 disable");
    frame(8'h06, 1, 0, 0, 3, 0, "R9 partial enable");
    frame(8'h06, 1, 0, 0, 0, 1, "R10 enable mode 1,1");
    frame(8'h03, 1, 0, 0, 0, 0, "R11 unknown opcode");
    frame(8'h02, 4, 16'hF7FF, 8'h3C, 0, 1, "R6 write top address mode 1,1");
    frame(8'h06, 1, 0, 0, 0, 0, "R3 enable");
    frame(8'h01, 2, 0, 8'hF4, 0, 0, "R7 status write protect 01");
    frame(8'h06, 1, 0, 0, 0, 0, "R3 enable");
    frame(8'h02, 4, 16'h0600, 8'h11, 0, 0, "R5 write refused 0x600");
    frame(8'h02, 4, 16'h05FF, 8'h22, 0, 0, "R5 R8 write accepted 0x5FF");
    frame(8'h06, 1, 0, 0, 0, 1, "R3 enable");
    frame(8'h02, 4, 16'h0010, 8'h77, 5, 1, "R9 partial write");
    frame(8'h01, 2, 0, 8'h0C, 0, 1, "R7 protect 11");
    frame(8'h06, 1, 0, 0, 0, 0, "R3 enable");
    frame(8'h02, 4, 16'h0000, 8'h99, 0, 0, "R5 all protected");
    for (int k = 0; k < 220; k++) begin
      logic [7:0] op;
      int nb, r;
      r = $urandom_range(0, 9);
      op = (r < 4) ? 8'h06 : (r < 5) ? 8'h04 : (r < 8) ? 8'h02 : (r < 9) ? 8'h01 : 8'($urandom);
      nb = (op == 8'h02) ? 4 : (op == 8'h01) ? 2 : 1;
      if ($urandom_range(0, 7) == 0) nb = $urandom_range(1, 4);
      frame(op, nb, 16'($urandom), 8'($urandom), ($urandom_range(0, 9) == 0) ? $urandom_range(1, 7) : 0,
            1'($urandom), "R10 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule